// File: doc/BRIEF.md
# Host Register Access Port

This block is the slave side of an asynchronous host bus. A processor outside the chip selects the block with an active-low select line. It then pulls an active-low strobe low, with a direction line that marks the cycle as a read or a write. The block brings the three control lines into its own clock domain through two-flop synchronizers. When the synchronized select and strobe both go low, it captures the 14-bit address and the 16-bit write data, and it issues exactly one access on an internal register port.

Completion is reported on an acknowledge pin that normally floats. The block drives that pin low once the access is done. It keeps driving it low until the host lifts the strobe or the select, and then lets it float again. The bidirectional data pins are modelled as a separate input, output and output enable. The internal port serves a small test register file that is mapped at the bottom of the address space.

The controller is a three-state machine. IDLE waits for the start condition and moves to ISSUE on it. ISSUE performs the single access for one clock and always moves to HOLD. HOLD drives the acknowledge, stays in HOLD while select and strobe remain low, and returns to IDLE once either of them is high.

Top module: `hostport_slave`

## Requirements
- R1: After reset the acknowledge is not driven (ack_oe = 0), the data output enable is 0 and bus_dout is 0.
- R2: A direction input of 0 writes and a value of 1 reads. A value written to a register address in the range 0 to NREGS-1 (default 8) is returned by a later read of that address. A register that has never been written reads back as 0.
- R3: The acknowledge is driven (ack_oe = 1) from the fourth rising clock edge after select and strobe are both low. It is not driven after the third edge.
- R4: The acknowledge stays driven while select and strobe remain low. It is released on the third rising edge after either of them goes high.
- R5: bus_doe is 1 exactly while select is low, strobe is low and the direction input is 1. It is 0 throughout a write.
- R6: Holding the strobe low for any length of time performs only one internal access.
- R7: The address and write data are taken at the start of the access. Changes to them while the strobe remains low have no effect.
- R8: An address at or above NREGS reads as 0, and a write to it changes no register.
- R9: A strobe given while select is high starts no access and produces no acknowledge.
- R10: Read data appears on bus_dout when the acknowledge is driven. It holds that value after the strobe is removed, until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Active-low select from the host |
| bus_strobe_n | input | 1 | Active-low transfer strobe |
| bus_rd_wr | input | 1 | Direction: 1 read, 0 write |
| bus_addr | input | 14 | Register address |
| bus_din | input | 16 | Write data from the host |
| bus_dout | output | 16 | Read data to the host |
| bus_doe | output | 1 | Data pin output enable |
| ack_oe | output | 1 | When 1 the acknowledge pin is driven low; otherwise it floats |

## Verification
The acknowledge is due on the fourth rising edge after select and strobe are both low. That is two synchronizer stages, one edge to enter ISSUE and one edge to enter HOLD. Read data is due on the same edge. The release is due on the third rising edge after the strobe goes high. The bench changes inputs on falling edges and samples on falling edges. For each access it checks that the acknowledge is still low after the third edge and high after the fourth. It checks that the acknowledge is still high two edges after release and low after the third. A monitor compares bus_dout against a queue of expected read values at the falling edge where the acknowledge first appears.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } hp_state_t;
endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end
        assign q_sync[i] = s2;
    end
endmodule

// File: rtl/hp_ctrl.sv
module hp_ctrl
    import hp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_s_n,
    input  logic          strobe_s_n,
    input  logic          rw_s,
    input  logic [AW-1:0] addr_raw,
    input  logic [DW-1:0] din_raw,
    output logic          req_wr,
    output logic          req_rd,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_wdata,
    output logic          ack_oe
);
    hp_state_t state, state_nx;
    logic active, active_q, start;
    logic rw_q;

    assign active = ~sel_s_n & ~strobe_s_n;
    assign start  = active & ~active_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_HOLD;
            ST_HOLD:  if (!active) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            active_q  <= 1'b0;
            rw_q      <= 1'b1;
            req_addr  <= '0;
            req_wdata <= '0;
        end else begin
            state    <= state_nx;
            active_q <= active;
            if (state == ST_IDLE && start) begin
                rw_q      <= rw_s;
                req_addr  <= addr_raw;
                req_wdata <= din_raw;
            end
        end
    end

    always_comb begin
        req_wr = 1'b0;
        req_rd = 1'b0;
        ack_oe = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin
                req_wr = ~rw_q;
                req_rd = rw_q;
            end
            ST_HOLD:  ack_oe = 1'b1;
            default:  ;
        endcase
    end

    p_single_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ISSUE |=> state == ST_HOLD);
    p_hold_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && $past(state) != ST_HOLD) |-> $past(state) == ST_ISSUE);
    p_issue_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_ISSUE |-> $past(~sel_s_n));
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !active) |=> state == ST_IDLE);
endmodule

// File: rtl/hp_regfile.sv
module hp_regfile #(
    parameter int NREGS = 8,
    parameter int AW    = 14,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int            IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam logic [AW-1:0] LIMIT = AW'(NREGS);

    logic [NREGS-1:0][DW-1:0] store;
    logic                     in_range;
    logic [IDX_W-1:0]         idx;

    assign in_range = addr < LIMIT;
    assign idx      = addr[IDX_W-1:0];
    assign rdata    = in_range ? store[idx] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store <= '0;
        else if (wr_en && in_range) store[idx] <= wdata;
    end

    p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && in_range) |=> $stable(store));
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hp_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_strobe_n,
    input  logic              bus_rd_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              ack_oe
);
    logic [2:0]        ctl_s;
    logic              req_wr, req_rd;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rdata;

    hp_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({bus_rd_wr, bus_strobe_n, bus_sel_n}),
        .q_sync(ctl_s)
    );

    hp_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sel_s_n(ctl_s[0]), .strobe_s_n(ctl_s[1]), .rw_s(ctl_s[2]),
        .addr_raw(bus_addr), .din_raw(bus_din),
        .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ack_oe(ack_oe)
    );

    hp_regfile #(.NREGS(NREGS), .AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(req_wr), .addr(req_addr), .wdata(req_wdata),
        .rdata(rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_dout <= '0;
        else if (req_rd) bus_dout <= rdata;
    end

    assign bus_doe = ~bus_sel_n & ~bus_strobe_n & bus_rd_wr;

    p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> $stable(bus_dout));
    p_no_rd_wr_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_rd && req_wr));
endmodule

// File: tb/sim_hostport_slave.sv
module sim_hostport_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1, strobe_n = 1'b1, rd_wr = 1'b1;
    logic [13:0] addr = '0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        doe, ack;

    int checks = 0, failures = 0;
    logic [15:0] exp_q[$];
    logic        ack_prev = 1'b0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    hostport_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_strobe_n(strobe_n),
        .bus_rd_wr(rd_wr), .bus_addr(addr), .bus_din(din),
        .bus_dout(dout), .bus_doe(doe), .ack_oe(ack)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: read data compared when acknowledge first appears (R10, R2)
    always @(negedge clk) begin
        if (ack && !ack_prev && rd_wr && !sel_n) begin
            if (exp_q.size() == 0) chk("R10 unexpected read", 16'h1, 16'h0);
            else chk("R2/R10 read data", dout, exp_q.pop_front());
        end
        ack_prev <= ack;
    end

    task automatic access(input logic rw, input logic [13:0] a, input logic [15:0] d,
                          input int hold, input logic [15:0] exp_rd);
        @(negedge clk);
        if (rw) exp_q.push_back(exp_rd);
        rd_wr = rw; addr = a; din = d; sel_n = 1'b0; strobe_n = 1'b0;
        #1 chk("R5 doe during access", {15'd0, doe}, {15'd0, rw});
        repeat (3) @(posedge clk);
        @(negedge clk) chk("R3 ack not before edge 4", {15'd0, ack}, 16'd0);
        @(posedge clk);
        @(negedge clk) chk("R3 ack at edge 4", {15'd0, ack}, 16'd1);
        // R7: disturb address and data after the start
        addr = a ^ 14'h1; din = ~d;
        repeat (hold) @(negedge clk);
        chk("R4 ack held", {15'd0, ack}, 16'd1);
        strobe_n = 1'b1;
        #1 chk("R5 doe after strobe", {15'd0, doe}, 16'd0);
        repeat (2) @(posedge clk);
        @(negedge clk) chk("R4 ack still held", {15'd0, ack}, 16'd1);
        @(posedge clk);
        @(negedge clk) chk("R4 ack released", {15'd0, ack}, 16'd0);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ack", {15'd0, ack}, 16'd0);
        chk("R1 reset doe", {15'd0, doe}, 16'd0);
        chk("R1 reset dout", dout, 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        access(1'b0, 14'd1, 16'hA5A5, 1, 16'h0);   // R2 write
        access(1'b0, 14'd7, 16'h1234, 1, 16'h0);
        access(1'b1, 14'd1, 16'h0, 1, 16'hA5A5);    // R2 read back
        access(1'b1, 14'd3, 16'h0, 1, 16'h0000);    // R2 unwritten
        access(1'b1, 14'd7, 16'h0, 1, 16'h1234);
        // R10: value kept after strobe removed and across a write
        repeat (5) @(negedge clk);
        chk("R10 dout held", dout, 16'h1234);
        access(1'b0, 14'd4, 16'h0BAD, 1, 16'h0);
        chk("R10 dout held over write", dout, 16'h1234);

        // R8: out-of-range addresses
        access(1'b0, 14'd8, 16'hFFFF, 1, 16'h0);
        access(1'b0, 14'h3FF8, 16'hEEEE, 1, 16'h0);
        access(1'b1, 14'd0, 16'h0, 1, 16'h0000);    // R8 no alias at 0
        access(1'b1, 14'd8, 16'h0, 1, 16'h0000);    // R8 reads zero

        // R9: strobe with select high
        @(negedge clk);
        rd_wr = 1'b0; addr = 14'd1; din = 16'h5555; strobe_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk) chk("R9 no ack without select", {15'd0, ack}, 16'd0);
        end
        strobe_n = 1'b1;
        repeat (3) @(negedge clk);
        access(1'b1, 14'd1, 16'h0, 1, 16'hA5A5);    // R9 no write happened

        // R6/R7: long strobe, inputs changed during it
        access(1'b0, 14'd2, 16'h1111, 20, 16'h0);
        access(1'b1, 14'd2, 16'h0, 1, 16'h1111);    // R7 captured value
        access(1'b1, 14'd3, 16'h0, 1, 16'h0000);    // R6 no second write
        access(1'b1, 14'd2, 16'h0, 12, 16'h1111);   // R6 long read

        chk("R2 all reads seen", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule